// File: doc/BRIEF.md
# Chainable Event Counter Bank

A bank of free-running 32-bit event counters programmed through a small memory-mapped register port. Each counter has its own 8-bit selector that picks one of 256 single-bit event inputs, which are sampled every clock. Counting is gated by one global enable and by a per-counter enable. Per-counter enables and interrupt enables are changed through separate set and clear addresses, so independent agents can change single bits without a read-modify-write.

Any odd counter can be chained to the even counter below it. It then counts that counter's wraps and the pair forms one 64-bit count. Each counter sets a sticky overflow status bit either when it wraps or, in a per-counter alternative mode, on every change of its top bit. The second mode lets software leave 32-bit counters running and sample them twice per wrap period. A single level interrupt reports any enabled status bit.

Top module: `evctr_bank`

## Requirements
- R1: After reset all counters, enables, selectors, chain and mode bits, overflow status and the interrupt are zero. Reads of unmapped addresses return zero. Read data appears on `bus_rdata_o` in the cycle after the read request and is zero otherwise.
- R2: Counter n (count at 0x420+8n, selector in bits 7:0 at 0x220+8n) increments only in a cycle where global enable (bit 0 at 0x500), its enable bit and its selected source are all high. Selector code 0x01 counts every cycle. Any other code k selects `ev_i[k]`.
- R3: A counter at all ones wraps to zero on its next increment, and the wrap sets its overflow status bit (bit n at 0x740).
- R4: Writing ones to 0x508 / 0x50C sets / clears counter-enable bits, and writing ones to 0x510 / 0x514 sets / clears interrupt-enable bits. Zero bits change nothing. Reading either address of a pair returns the current mask.
- R5: With chain bit n+1 (odd n+1) set at 0x718, counter n+1 increments on each wrap of counter n instead of on its own selected source. Writes to even bit positions of 0x718 are ignored and read back as zero.
- R6: Overflow status bits are sticky and cleared by writing ones to 0x740. Zero bits have no effect. A clear in the same cycle as a new overflow of that counter leaves the bit set.
- R7: With bit n set at 0x96C, counter n sets its status bit on every change of bit 31, upward or downward. With the bit clear, only a wrap sets it.
- R8: Writing a counter address loads the written value. A load in the same cycle as an increment wins and the increment is lost.
- R9: `irq_o` is high while any counter has both its status bit and its interrupt-enable bit set.
- R10: A write to 0x500 with bit 1 set zeroes every counter and every status bit, and bit 0 of the same write becomes the global enable. With global enable low, all counts hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_vld_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 12 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| ev_i | input | 256 | Event inputs, indexed by selector code |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situations to reach are the same-cycle collisions: a status clear landing in the exact cycle a counter wraps, and a counter load landing in a cycle where an increment is also due. Both depend on the cycle of a bus write relative to counting. The bench therefore opens the global enable with one write and places the colliding write on the very next bus cycle. The counter was preloaded one step below its wrap or load point, so the collision falls on a known edge. Chaining is reached the same way: the even counter is preloaded to all ones while its odd partner also selects the every-cycle code. A partner that ignored the chain bit would then end with a visibly wrong count.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

    // register addresses (byte offsets)
    localparam logic [11:0] A_CNT_BASE = 12'h420;
    localparam logic [11:0] A_SEL_BASE = 12'h220;
    localparam logic [11:0] A_GCTL     = 12'h500;
    localparam logic [11:0] A_CEN_SET  = 12'h508;
    localparam logic [11:0] A_CEN_CLR  = 12'h50C;
    localparam logic [11:0] A_IEN_SET  = 12'h510;
    localparam logic [11:0] A_IEN_CLR  = 12'h514;
    localparam logic [11:0] A_GANG     = 12'h718;
    localparam logic [11:0] A_OVS      = 12'h740;
    localparam logic [11:0] A_MSB      = 12'h96C;
    localparam int unsigned SLOT_STRIDE = 8;

    // selector code that counts every clock
    localparam logic [7:0] CYC_CODE = 8'h01;

    typedef enum logic [3:0] {
        RG_NONE,
        RG_GCTL,
        RG_CEN_SET,
        RG_CEN_CLR,
        RG_IEN_SET,
        RG_IEN_CLR,
        RG_GANG,
        RG_OVS,
        RG_MSB
    } reg_e;

endpackage

// File: rtl/evctr_unit.sv
module evctr_unit #(
    parameter int unsigned CTR_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             ld_i,
    input  logic [CTR_W-1:0] ld_val_i,
    input  logic             clr_i,
    input  logic             msb_mode_i,
    output logic [CTR_W-1:0] cnt_o,
    output logic             carry_o,
    output logic             flag_o
);

    typedef struct packed {
        logic [CTR_W-1:0] cnt;
    } unit_st_t;

    unit_st_t         st_d, st_q;
    logic [CTR_W-1:0] nxt;
    logic             step;

    always_comb begin
        st_d    = st_q;
        nxt     = st_q.cnt + 1'b1;
        step    = inc_i & ~ld_i & ~clr_i;
        carry_o = step & (&st_q.cnt);
        flag_o  = msb_mode_i ? (step & (st_q.cnt[CTR_W-1] ^ nxt[CTR_W-1]))
                             : carry_o;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (ld_i) begin
            st_d.cnt = ld_val_i;
        end else if (inc_i) begin
            st_d.cnt = nxt;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (inc_i && !ld_i && !clr_i && (&cnt_o)) |=> (cnt_o == '0));

    p_load_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_i && !clr_i) |=> (cnt_o == $past(ld_val_i)));

    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!inc_i && !ld_i && !clr_i) |=> $stable(cnt_o));

endmodule

// File: rtl/evctr_status.sv
module evctr_status #(
    parameter int unsigned NUM_CTR = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_CTR-1:0] flag_i,
    input  logic [NUM_CTR-1:0] wclr_i,
    input  logic               clr_all_i,
    input  logic [NUM_CTR-1:0] ien_i,
    output logic [NUM_CTR-1:0] ovs_o,
    output logic               irq_o
);

    typedef struct packed {
        logic [NUM_CTR-1:0] ovs;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_all_i) begin
            st_d.ovs = '0;
        end else begin
            // a new overflow outranks a same-cycle clear
            st_d.ovs = (st_q.ovs & ~wclr_i) | flag_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovs_o = st_q.ovs;
    assign irq_o = |(st_q.ovs & ien_i);

    p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i != '0) |=> ((ovs_o & $past(flag_i)) == $past(flag_i)));

    p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((wclr_i & ~flag_i) != '0) |=> ((ovs_o & $past(wclr_i & ~flag_i)) == '0));

    p_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_all_i && wclr_i == '0) |=> ((ovs_o & $past(ovs_o)) == $past(ovs_o)));

endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
    import evctr_pkg::*;
#(
    parameter int unsigned NUM_CTR = 8,
    parameter int unsigned CTR_W   = 32,
    parameter int unsigned SEL_W   = 8,
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned EV_NUM = 2 ** SEL_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_vld_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [EV_NUM-1:0] ev_i,
    output logic              irq_o
);

    function automatic logic [NUM_CTR-1:0] odd_mask_f();
        logic [NUM_CTR-1:0] m;
        m = '0;
        for (int i = 1; i < NUM_CTR; i += 2) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [NUM_CTR-1:0] ODD_MASK = odd_mask_f();

    typedef struct packed {
        logic                          gen_en;
        logic [NUM_CTR-1:0]            cen;
        logic [NUM_CTR-1:0]            ien;
        logic [NUM_CTR-1:0]            gang;
        logic [NUM_CTR-1:0]            msbm;
        logic [NUM_CTR-1:0][SEL_W-1:0] sel;
        logic [DATA_W-1:0]             rdata;
    } bank_st_t;

    bank_st_t                      st_d, st_q;
    reg_e                          kind;
    logic [NUM_CTR-1:0]            cnt_hit, sel_hit;
    logic                          wr, rd, unit_clr;
    logic [NUM_CTR-1:0]            ld, inc, carry, flag, ovs_clr, ovs;
    logic [NUM_CTR-1:0][CTR_W-1:0] cnt;
    logic [DATA_W-1:0]             rv;

    // address decode
    always_comb begin
        kind    = RG_NONE;
        cnt_hit = '0;
        sel_hit = '0;
        if      (bus_addr_i == ADDR_W'(A_GCTL))    kind = RG_GCTL;
        else if (bus_addr_i == ADDR_W'(A_CEN_SET)) kind = RG_CEN_SET;
        else if (bus_addr_i == ADDR_W'(A_CEN_CLR)) kind = RG_CEN_CLR;
        else if (bus_addr_i == ADDR_W'(A_IEN_SET)) kind = RG_IEN_SET;
        else if (bus_addr_i == ADDR_W'(A_IEN_CLR)) kind = RG_IEN_CLR;
        else if (bus_addr_i == ADDR_W'(A_GANG))    kind = RG_GANG;
        else if (bus_addr_i == ADDR_W'(A_OVS))     kind = RG_OVS;
        else if (bus_addr_i == ADDR_W'(A_MSB))     kind = RG_MSB;
        for (int n = 0; n < NUM_CTR; n++) begin
            cnt_hit[n] = (bus_addr_i == ADDR_W'(A_CNT_BASE + n * SLOT_STRIDE));
            sel_hit[n] = (bus_addr_i == ADDR_W'(A_SEL_BASE + n * SLOT_STRIDE));
        end
    end

    // next-state of the control registers and read data
    always_comb begin
        st_d     = st_q;
        wr       = bus_vld_i & bus_we_i;
        rd       = bus_vld_i & ~bus_we_i;
        unit_clr = wr && (kind == RG_GCTL) && bus_wdata_i[1];
        ovs_clr  = (wr && (kind == RG_OVS)) ? bus_wdata_i[NUM_CTR-1:0] : '0;

        if (wr) begin
            case (kind)
                RG_GCTL:    st_d.gen_en = bus_wdata_i[0];
                RG_CEN_SET: st_d.cen    = st_q.cen | bus_wdata_i[NUM_CTR-1:0];
                RG_CEN_CLR: st_d.cen    = st_q.cen & ~bus_wdata_i[NUM_CTR-1:0];
                RG_IEN_SET: st_d.ien    = st_q.ien | bus_wdata_i[NUM_CTR-1:0];
                RG_IEN_CLR: st_d.ien    = st_q.ien & ~bus_wdata_i[NUM_CTR-1:0];
                RG_GANG:    st_d.gang   = bus_wdata_i[NUM_CTR-1:0] & ODD_MASK;
                RG_MSB:     st_d.msbm   = bus_wdata_i[NUM_CTR-1:0];
                default: ;
            endcase
        end

        for (int n = 0; n < NUM_CTR; n++) begin
            ld[n] = wr & cnt_hit[n];
            if (wr && sel_hit[n]) st_d.sel[n] = bus_wdata_i[SEL_W-1:0];
        end

        rv = '0;
        case (kind)
            RG_GCTL:                rv[0]         = st_q.gen_en;
            RG_CEN_SET, RG_CEN_CLR: rv[NUM_CTR-1:0] = st_q.cen;
            RG_IEN_SET, RG_IEN_CLR: rv[NUM_CTR-1:0] = st_q.ien;
            RG_GANG:                rv[NUM_CTR-1:0] = st_q.gang;
            RG_OVS:                 rv[NUM_CTR-1:0] = ovs;
            RG_MSB:                 rv[NUM_CTR-1:0] = st_q.msbm;
            default: ;
        endcase
        for (int n = 0; n < NUM_CTR; n++) begin
            if (cnt_hit[n]) rv = DATA_W'(cnt[n]);
            if (sel_hit[n]) rv = DATA_W'(st_q.sel[n]);
        end
        st_d.rdata = rd ? rv : '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // counter slices; odd slices carry the chain option
    for (genvar n = 0; n < NUM_CTR; n++) begin : g_ctr
        logic ev_sel;
        logic src;

        always_comb begin
            ev_sel = (st_q.sel[n] == SEL_W'(CYC_CODE)) ? 1'b1 : ev_i[st_q.sel[n]];
        end

        if (n % 2 == 1) begin : g_odd
            always_comb begin
                src = st_q.gang[n] ? carry[n-1] : ev_sel;
            end

            p_chain_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (st_q.gang[n] && carry[n-1] && st_q.gen_en && st_q.cen[n]
                 && !ld[n] && !unit_clr)
                |=> (cnt[n] == $past(cnt[n]) + 1'b1));
        end else begin : g_even
            always_comb begin
                src = ev_sel;
            end
        end

        always_comb begin
            inc[n] = st_q.gen_en & st_q.cen[n] & src;
        end

        evctr_unit #(
            .CTR_W (CTR_W)
        ) u_unit (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .inc_i      (inc[n]),
            .ld_i       (ld[n]),
            .ld_val_i   (bus_wdata_i[CTR_W-1:0]),
            .clr_i      (unit_clr),
            .msb_mode_i (st_q.msbm[n]),
            .cnt_o      (cnt[n]),
            .carry_o    (carry[n]),
            .flag_o     (flag[n])
        );
    end

    evctr_status #(
        .NUM_CTR (NUM_CTR)
    ) u_status (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .flag_i    (flag),
        .wclr_i    (ovs_clr),
        .clr_all_i (unit_clr),
        .ien_i     (st_q.ien),
        .ovs_o     (ovs),
        .irq_o     (irq_o)
    );

    assign bus_rdata_o = st_q.rdata;

    p_rdata_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_vld_i && !bus_we_i) |=> (bus_rdata_o == '0));

    p_gang_even_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_vld_i && bus_we_i && bus_addr_i == ADDR_W'(A_GANG))
        |=> ((st_q.gang & ~ODD_MASK) == '0));

endmodule

// File: tb/test_evctr_bank.sv
`timescale 1ns/1ps
module test_evctr_bank;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_vld = 1'b0;
    logic         bus_we = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [255:0] ev = '0;
    logic         irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    evctr_bank i_evctr_bank (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_vld_i   (bus_vld),
        .bus_we_i    (bus_we),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .ev_i        (ev),
        .irq_o       (irq)
    );

    // monitor: read data is valid just after the edge following the request
    always @(posedge clk) begin
        logic fire;
        logic [31:0] e;
        string t;
        fire = bus_vld & ~bus_we;
        #1;
        if (fire) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty actual=%h expected=none", bus_rdata);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_vld = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_vld = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        bus_vld = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_vld = 1'b0;
    endtask

    task automatic chk_irq(input logic e, input string t);
        n_chk++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", t, irq, e);
        end
    endtask

    // global enable open for k+1 counting edges
    task automatic run(input int k);
        wr(12'h500, 32'h1);
        repeat (k) @(negedge clk);
        wr(12'h500, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(12'h420, 32'h0, "R1 counter0 reset");
        rd(12'h508, 32'h0, "R1 enables reset");
        rd(12'h740, 32'h0, "R1 status reset");
        rd(12'h004, 32'h0, "R1 unmapped read");
        rd(12'h500, 32'h0, "R1 global reset");
        chk_irq(1'b0, "R1 irq reset");

        // R2 gating and source selection
        ev[8'h20] = 1'b1;
        wr(12'h220, 32'h01);
        wr(12'h228, 32'h20);
        wr(12'h230, 32'h21);
        wr(12'h238, 32'h01);
        wr(12'h508, 32'h07);
        repeat (3) @(negedge clk);
        rd(12'h420, 32'h0, "R2 no count while global off");
        run(4);
        rd(12'h420, 32'd5, "R2 cycle code");
        rd(12'h428, 32'd5, "R2 event input high");
        rd(12'h430, 32'd0, "R2 event input low");
        rd(12'h438, 32'd0, "R2 counter disabled");
        repeat (4) @(negedge clk);
        rd(12'h420, 32'd5, "R10 hold after global off");

        // R4 set/clear enables
        wr(12'h508, 32'h08);
        rd(12'h508, 32'h0F, "R4 enable set");
        wr(12'h50C, 32'h02);
        rd(12'h50C, 32'h0D, "R4 enable clear");
        wr(12'h510, 32'h11);
        rd(12'h514, 32'h11, "R4 irq-enable set");
        wr(12'h514, 32'h10);
        rd(12'h510, 32'h01, "R4 irq-enable clear");
        wr(12'h50C, 32'hFF);
        rd(12'h508, 32'h00, "R4 enable clear all");

        // R8 load, and load beating an increment
        wr(12'h420, 32'hFFFF_FFFE);
        rd(12'h420, 32'hFFFF_FFFE, "R8 load");
        wr(12'h508, 32'h01);
        wr(12'h500, 32'h1);
        wr(12'h420, 32'h100);
        wr(12'h500, 32'h0);
        rd(12'h420, 32'h101, "R8 load wins over increment");

        // R3 wrap and R9 interrupt
        wr(12'h420, 32'hFFFF_FFFE);
        run(1);
        rd(12'h420, 32'h0, "R3 wrap to zero");
        rd(12'h740, 32'h1, "R3 wrap sets status");
        chk_irq(1'b1, "R9 irq with status and enable");
        wr(12'h514, 32'h1);
        chk_irq(1'b0, "R9 irq masked");
        wr(12'h510, 32'h1);
        chk_irq(1'b1, "R9 irq re-enabled");
        wr(12'h740, 32'h0);
        rd(12'h740, 32'h1, "R6 zero write keeps status");
        wr(12'h740, 32'h1);
        rd(12'h740, 32'h0, "R6 one write clears status");
        chk_irq(1'b0, "R9 irq after clear");

        // R7 top-bit toggle mode
        wr(12'h50C, 32'hFF);
        wr(12'h240, 32'h01);
        wr(12'h248, 32'h01);
        wr(12'h96C, 32'h10);
        wr(12'h440, 32'h7FFF_FFFF);
        wr(12'h448, 32'h7FFF_FFFF);
        wr(12'h508, 32'h30);
        run(0);
        rd(12'h440, 32'h8000_0000, "R7 counter4 value");
        rd(12'h740, 32'h10, "R7 upward toggle flags only mode counter");
        wr(12'h740, 32'hFF);
        wr(12'h440, 32'hFFFF_FFFF);
        run(0);
        rd(12'h740, 32'h10, "R7 downward toggle flags");
        wr(12'h740, 32'hFF);

        // R5 chaining
        wr(12'h50C, 32'hFF);
        wr(12'h250, 32'h01);
        wr(12'h258, 32'h01);
        wr(12'h718, 32'hC0);
        rd(12'h718, 32'h80, "R5 even chain bit ignored");
        wr(12'h450, 32'hFFFF_FFFF);
        wr(12'h458, 32'd5);
        wr(12'h508, 32'hC0);
        run(2);
        rd(12'h450, 32'd2, "R5 low half");
        rd(12'h458, 32'd6, "R5 high half counts carries");
        rd(12'h740, 32'h40, "R5 low half wrap status");
        wr(12'h740, 32'hFF);

        // R6 clear colliding with a new overflow
        wr(12'h50C, 32'hFF);
        wr(12'h508, 32'h01);
        wr(12'h420, 32'hFFFF_FFFF);
        wr(12'h500, 32'h1);
        wr(12'h740, 32'h1);
        wr(12'h500, 32'h0);
        rd(12'h740, 32'h1, "R6 overflow beats clear");
        rd(12'h420, 32'h1, "R6 counter after wrap");
        chk_irq(1'b1, "R9 irq after collision");

        // R10 unit reset
        wr(12'h500, 32'h2);
        rd(12'h420, 32'h0, "R10 counter0 cleared");
        rd(12'h458, 32'h0, "R10 counter7 cleared");
        rd(12'h740, 32'h0, "R10 status cleared");
        rd(12'h500, 32'h0, "R10 global enable from write");
        chk_irq(1'b0, "R10 irq after unit reset");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_chk++;
            n_bad++;
            $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
        end
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule